// File: doc/BRIEF.md
# HDLC Transmit Buffer with Cyclic Repeat

This block is the transmit end of one HDLC channel. A host loads payload into a 32-byte buffer, one byte or one 16-bit word per write, and then starts transmission through an 8-bit write-only command port. A serializer moves the buffered bytes onto a single line output, one bit for each transmit clock enable, least significant bit first. Flags, CRC and zero-bit insertion belong to a later stage. In framed mode this block sends only the raw payload bits and raises an end-of-frame strobe when asked to.

A cyclic mode sends the loaded bytes over and over, fully transparent, without consuming them. It keeps going until a stop command arrives. A one-cycle "buffer free" pulse tells the host when the buffer has drained, so that it can load the next 32 bytes.

The write port uses valid/ready. `wr_ready` depends on `wr_word` and on the free space: it is high for a byte write when at least one slot is free, and for a word write when at least two slots are free. A write is taken on a clock where `wr_valid` and `wr_ready` are both high. The host should hold a write until it sees `wr_ready`. A write offered while `wr_ready` is low is not kept pending: it is dropped at once and the sticky `overflow` flag is set.

Top module: `hdlc_txrep`

## Requirements
- R1: After reset, `tx_line` is 1, `tx_active`, `frame_end`, `pool_ready` and `overflow` are 0, and `wr_ready` is 1 for both access sizes.
- R2: A byte write stores `wr_data[7:0]`. A word write stores `wr_data[7:0]` first and then `wr_data[15:8]`. The buffer holds 32 bytes. `wr_ready` is 0 for a byte write at 32 bytes and for a word write at 31 or more bytes.
- R3: A write offered with `wr_ready` low is dropped, so the buffer contents do not change. It sets `overflow`, which stays 1 until a flush command.
- R4: Each byte goes out on `tx_line` bit 0 first. A bit is presented from the clock edge that consumes the previous bit, or from the start command. It holds until the edge where `bit_en` is sampled high. Between enables the line does not change.
- R5: A command write with bit 2 set and bit 5 clear starts a single pass. The bytes are sent in the order they were stored, and each byte is removed once its last bit has been consumed. After the final byte, `tx_active` falls and `tx_line` returns to 1. Bit 2 is ignored while the buffer is empty or while a transmission is in progress.
- R6: If bit 1 is set in the same write as bit 2 (value 0x06), `frame_end` is 1 for exactly one cycle, the cycle after the edge that consumes the last bit. Without bit 1, `frame_end` stays 0.
- R7: `pool_ready` is 1 for exactly one cycle, the cycle after the buffer goes from non-empty to empty.
- R8: Writing 0x24 (bits 5 and 2) starts cyclic mode. The stored bytes are sent in order, and after the last one the sequence wraps to the first. No byte is removed, and neither `pool_ready` nor `frame_end` pulses.
- R9: During cyclic mode, any command write with bit 5 clear and bits 0 and 4 clear ends transmission on the next edge. `tx_line` returns to 1 and the stored bytes are kept, so a later 0x04 sends them once.
- R10: A command write with bit 0 or bit 4 set empties the buffer, stops the serializer and clears `overflow` on the next edge. If the buffer was non-empty, `pool_ready` then pulses. A data write in the same cycle is discarded.
- R11: Bits 7, 6 and 3 of a command write have no effect. On an idle block they start nothing, and during a pass they do not disturb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Host write offered |
| wr_ready | output | 1 | Room for the offered access size |
| wr_word | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| wr_data | input | 16 | Write data; low byte stored first |
| cmd_wr | input | 1 | Command write strobe |
| cmd_data | input | 8 | Command bits |
| bit_en | input | 1 | Transmit clock enable, one bit per high cycle |
| tx_line | output | 1 | Serial data out, idles at 1 |
| tx_active | output | 1 | Serializer busy |
| frame_end | output | 1 | One-cycle end-of-frame strobe |
| pool_ready | output | 1 | One-cycle pulse when the buffer drains |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
On every cycle, the assertions check the following: the line idles high, and it holds between enables and commands. `frame_end` always comes with `pool_ready` and lasts one cycle. Cyclic mode never produces a drain pulse. A flush always leaves the block idle and empty. `overflow` holds until a flush, and the byte count never exceeds the capacity. Only the bench scenarios can show the actual bit order, the low-before-high order of word writes and the wrap-around sequence in cyclic mode for every fill level from 1 to 32. They also show that a stopped cycle keeps its bytes and that dropped writes really are absent from the output.

// File: rtl/hdlc_txrep_pkg.sv
package hdlc_txrep_pkg;
  // command bit positions decoded by the command unit
  localparam int CB_SOFT_RST  = 0;
  localparam int CB_MARK_END  = 1;
  localparam int CB_SEND      = 2;
  localparam int CB_TX_RST    = 4;
  localparam int CB_CYCLIC    = 5;

  typedef struct packed {
    logic flush;
    logic start;
    logic start_cyc;
    logic start_mark;
    logic halt;
  } ctl_t;
endpackage

// File: rtl/hdlc_txrep_fifo.sv
module hdlc_txrep_fifo #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          push_word,
  input  logic [15:0]   push_data,
  input  logic          pop,
  input  logic [AW-1:0] rd_off,
  output logic [7:0]    rd_byte,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] free
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] add_n;
  logic [CW-1:0] sub_n;
  logic [AW-1:0] tail_p1;
  logic [AW-1:0] rd_addr;

  assign add_n   = push ? (push_word ? CW'(2) : CW'(1)) : '0;
  assign sub_n   = pop ? CW'(1) : '0;
  assign tail_p1 = tail_q + AW'(1);
  assign rd_addr = head_q + rd_off;
  assign rd_byte = mem[rd_addr];
  assign cnt     = cnt_q;
  assign free    = CW'(DEPTH) - cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= push_word ? tail_q + AW'(2) : tail_p1;
      if (pop)  head_q <= head_q + AW'(1);
      cnt_q <= cnt_q + add_n - sub_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) begin
      mem[tail_q] <= push_data[7:0];
      if (push_word) mem[tail_p1] <= push_data[15:8];
    end
  end
endmodule

// File: rtl/hdlc_txrep_cmd.sv
module hdlc_txrep_cmd
  import hdlc_txrep_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          cmd_wr,
  input  logic [7:0]    cmd_data,
  input  logic          busy,
  input  logic          cyc,
  input  logic [CW-1:0] cnt,
  output ctl_t          ctl
);
  logic do_flush;

  assign do_flush = cmd_wr && (cmd_data[CB_SOFT_RST] || cmd_data[CB_TX_RST]);

  always_comb begin
    ctl            = '0;
    ctl.flush      = do_flush;
    ctl.start      = cmd_wr && !do_flush && cmd_data[CB_SEND] && !busy && (cnt != '0);
    ctl.start_cyc  = cmd_data[CB_CYCLIC];
    ctl.start_mark = cmd_data[CB_MARK_END] && !cmd_data[CB_CYCLIC];
    ctl.halt       = do_flush || (cmd_wr && busy && cyc && !cmd_data[CB_CYCLIC]);
  end
endmodule

// File: rtl/hdlc_txrep_ser.sv
module hdlc_txrep_ser #(
  parameter int AW = 5,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          start,
  input  logic          start_cyc,
  input  logic          start_mark,
  input  logic          halt,
  input  logic [CW-1:0] cnt,
  input  logic [7:0]    rd_byte,
  output logic [AW-1:0] rd_off,
  output logic          pop,
  output logic          line,
  output logic          busy,
  output logic          cyc,
  output logic          frame_end
);
  logic          busy_q, cyc_q, mark_q, fe_q;
  logic [7:0]    sh_q;
  logic [2:0]    bcnt_q;
  logic [AW-1:0] idx_q;
  logic [AW-1:0] idx_nx;
  logic          byte_done;
  logic          last_out;

  assign idx_nx    = ((CW'(idx_q) + CW'(1)) == cnt) ? '0 : idx_q + AW'(1);
  assign byte_done = busy_q && bit_en && (bcnt_q == 3'd7);
  assign pop       = byte_done && !cyc_q && !halt;
  assign last_out  = pop && (cnt == CW'(1));
  assign rd_off    = !busy_q ? '0 : (cyc_q ? idx_nx : AW'(1));
  assign line      = busy_q ? sh_q[0] : 1'b1;
  assign busy      = busy_q;
  assign cyc       = cyc_q;
  assign frame_end = fe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cyc_q  <= 1'b0;
      mark_q <= 1'b0;
      fe_q   <= 1'b0;
      sh_q   <= '1;
      bcnt_q <= '0;
      idx_q  <= '0;
    end else begin
      fe_q <= last_out && mark_q;
      if (halt) begin
        busy_q <= 1'b0;
        cyc_q  <= 1'b0;
        mark_q <= 1'b0;
        bcnt_q <= '0;
        idx_q  <= '0;
      end else if (start) begin
        busy_q <= 1'b1;
        cyc_q  <= start_cyc;
        mark_q <= start_mark;
        sh_q   <= rd_byte;
        bcnt_q <= '0;
        idx_q  <= '0;
      end else if (busy_q && bit_en) begin
        bcnt_q <= bcnt_q + 3'd1;
        if (bcnt_q != 3'd7) begin
          sh_q <= {1'b1, sh_q[7:1]};
        end else if (cyc_q) begin
          idx_q <= idx_nx;
          sh_q  <= rd_byte;
        end else if (cnt == CW'(1)) begin
          busy_q <= 1'b0;
          mark_q <= 1'b0;
        end else begin
          sh_q <= rd_byte;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_txrep.sv
module hdlc_txrep
  import hdlc_txrep_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic        wr_word,
  input  logic [15:0] wr_data,
  input  logic        cmd_wr,
  input  logic [7:0]  cmd_data,
  input  logic        bit_en,
  output logic        tx_line,
  output logic        tx_active,
  output logic        frame_end,
  output logic        pool_ready,
  output logic        overflow
);
  ctl_t          ctl;
  logic [CW-1:0] fifo_cnt, fifo_free;
  logic [AW-1:0] rd_off;
  logic [7:0]    rd_byte;
  logic          pop, busy, cyc, push;
  logic          ovf_q, nz_q;

  assign wr_ready   = wr_word ? (fifo_free >= CW'(2)) : (fifo_free >= CW'(1));
  assign push       = wr_valid && wr_ready && !ctl.flush;
  assign tx_active  = busy;
  assign overflow   = ovf_q;
  assign pool_ready = nz_q && (fifo_cnt == '0);

  hdlc_txrep_cmd #(.CW(CW)) u_cmd (
    .cmd_wr   (cmd_wr),
    .cmd_data (cmd_data),
    .busy     (busy),
    .cyc      (cyc),
    .cnt      (fifo_cnt),
    .ctl      (ctl)
  );

  hdlc_txrep_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (ctl.flush),
    .push      (push),
    .push_word (wr_word),
    .push_data (wr_data),
    .pop       (pop),
    .rd_off    (rd_off),
    .rd_byte   (rd_byte),
    .cnt       (fifo_cnt),
    .free      (fifo_free)
  );

  hdlc_txrep_ser #(.AW(AW)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .start      (ctl.start),
    .start_cyc  (ctl.start_cyc),
    .start_mark (ctl.start_mark),
    .halt       (ctl.halt),
    .cnt        (fifo_cnt),
    .rd_byte    (rd_byte),
    .rd_off     (rd_off),
    .pop        (pop),
    .line       (tx_line),
    .busy       (busy),
    .cyc        (cyc),
    .frame_end  (frame_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      nz_q  <= 1'b0;
    end else begin
      nz_q <= (fifo_cnt != '0);
      if (ctl.flush)                 ovf_q <= 1'b0;
      else if (wr_valid && !wr_ready) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_txrep_chk.sv
module hdlc_txrep_chk #(
  parameter int DEPTH = 32,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          cmd_wr,
  input logic [7:0]    cmd_data,
  input logic          tx_line,
  input logic          tx_active,
  input logic          frame_end,
  input logic          pool_ready,
  input logic          overflow,
  input logic          cyc,
  input logic [CW-1:0] cnt
);
  logic flush_cmd;
  assign flush_cmd = cmd_wr && (cmd_data[0] || cmd_data[4]);

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> tx_line);

  // R4
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!bit_en && !cmd_wr) && tx_active && $past(tx_active)) |-> $stable(tx_line));

  // R6
  frame_end_with_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> pool_ready);

  // R6
  frame_end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  // R7
  pool_ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pool_ready |=> !pool_ready);

  // R8
  no_drain_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && cyc) |-> (!pool_ready && !frame_end));

  // R3
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !flush_cmd) |=> overflow);

  // R10
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_cmd |=> (!tx_active && cnt == '0 && !overflow));

  // R2
  capacity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

bind hdlc_txrep hdlc_txrep_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .cmd_wr     (cmd_wr),
  .cmd_data   (cmd_data),
  .tx_line    (tx_line),
  .tx_active  (tx_active),
  .frame_end  (frame_end),
  .pool_ready (pool_ready),
  .overflow   (overflow),
  .cyc        (cyc),
  .cnt        (fifo_cnt)
);

// File: tb/hdlc_txrep_test.sv
`timescale 1ns/1ps
module hdlc_txrep_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_word = 1'b0;
  logic [15:0] wr_data = '0;
  logic cmd_wr = 1'b0;
  logic [7:0] cmd_data = '0;
  logic bit_en = 1'b0;
  logic wr_ready, tx_line, tx_active, frame_end, pool_ready, overflow;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] pat [32];

  always #2.5 clk = ~clk;

  hdlc_txrep uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_word(wr_word), .wr_data(wr_data), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .bit_en(bit_en), .tx_line(tx_line), .tx_active(tx_active),
    .frame_end(frame_end), .pool_ready(pool_ready), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_pat(input int n);
    for (int i = 0; i < 32; i++) pat[i] = 8'((i * 37 + n * 11 + 5) & 255);
  endtask

  task automatic wr(input bit w, input logic [15:0] d);
    wr_valid = 1'b1; wr_word = w; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_word = 1'b0;
  endtask

  task automatic load(input int n, input bit words);
    int i = 0;
    while (i < n) begin
      if (words && (n - i) >= 2) begin
        wr(1'b1, {pat[i+1], pat[i]});
        i += 2;
      end else begin
        wr(1'b0, {8'h00, pat[i]});
        i += 1;
      end
    end
  endtask

  task automatic cmd(input logic [7:0] v);
    cmd_wr = 1'b1; cmd_data = v;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_data = '0;
  endtask

  task automatic shift_one(input bit e, input bit cyc_mode);
    chk(tx_line == e, "R4 bit", tx_line, e);
    @(negedge clk);
    chk(tx_line == e, "R4 hold", tx_line, e);
    if (cyc_mode) chk(!pool_ready && !frame_end, "R8 no pulse", {pool_ready, frame_end}, 0);
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit cyc_mode);
    for (int k = 0; k < 8; k++) shift_one(b[k], cyc_mode);
  endtask

  task automatic end_checks(input bit mark);
    chk(!tx_active, "R5 idle after pass", tx_active, 0);
    chk(tx_line, "R5 line high", tx_line, 1);
    chk(frame_end == mark, "R6 frame_end", frame_end, mark);
    chk(pool_ready, "R7 pool_ready", pool_ready, 1);
    @(negedge clk);
    chk(!frame_end && !pool_ready, "R7 R6 single cycle", {frame_end, pool_ready}, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_line, "R1 line", tx_line, 1);
    chk(!tx_active && !frame_end && !pool_ready && !overflow, "R1 outputs",
        {tx_active, frame_end, pool_ready, overflow}, 0);
    chk(wr_ready, "R1 ready byte", wr_ready, 1);
    wr_word = 1'b1; #1;
    chk(wr_ready, "R1 ready word", wr_ready, 1);
    wr_word = 1'b0;
    @(negedge clk);

    // single-pass sweep (R2 R5 R6 R7)
    foreach (pat[j]) begin end
    for (int s = 0; s < 7; s++) begin
      int n;
      bit mark;
      case (s)
        0: n = 1; 1: n = 2; 2: n = 3; 3: n = 8; 4: n = 17; 5: n = 31; default: n = 32;
      endcase
      mark = n[1];
      set_pat(n);
      load(n, n[0]);
      if (n == 31) begin
        wr_word = 1'b1; #1;
        chk(!wr_ready, "R2 word ready at 31", wr_ready, 0);
        wr_word = 1'b0; #1;
        chk(wr_ready, "R2 byte ready at 31", wr_ready, 1);
      end
      if (n == 32) begin
        wr_word = 1'b0; #1;
        chk(!wr_ready, "R2 byte ready at 32", wr_ready, 0);
      end
      @(negedge clk);
      chk(!tx_active, "R5 idle before start", tx_active, 0);
      cmd(mark ? 8'h06 : 8'h04);
      chk(tx_active, "R5 started", tx_active, 1);
      for (int i = 0; i < n; i++) send_byte(pat[i], 1'b0);
      end_checks(mark);
    end

    // overflow: extra write dropped, flag sticky (R3)
    set_pat(40);
    load(32, 1'b1);
    wr(1'b0, 16'h00EE);
    chk(overflow, "R3 overflow set", overflow, 1);
    cmd(8'h04);
    for (int i = 0; i < 32; i++) send_byte(pat[i], 1'b0);
    end_checks(1'b0);
    chk(overflow, "R3 overflow sticky", overflow, 1);

    // flush mid-pass (R10)
    load(2, 1'b1);
    cmd(8'h04);
    for (int k = 0; k < 3; k++) shift_one(pat[0][k], 1'b0);
    cmd(8'h10);
    chk(!tx_active && tx_line, "R10 flush idle", {tx_active, tx_line}, 1);
    chk(pool_ready, "R10 drain pulse", pool_ready, 1);
    chk(!overflow, "R10 overflow cleared", overflow, 0);
    @(negedge clk);
    cmd(8'h04);
    chk(!tx_active, "R5 start on empty ignored", tx_active, 0);

    // ignored command bits (R11)
    set_pat(3);
    load(3, 1'b0);
    cmd(8'hC8);
    chk(!tx_active && tx_line && !pool_ready, "R11 idle unaffected",
        {tx_active, tx_line, pool_ready}, 3'b010);
    cmd(8'h04);
    send_byte(pat[0], 1'b0);
    cmd(8'hCC);
    chk(tx_active, "R11 pass undisturbed", tx_active, 1);
    send_byte(pat[1], 1'b0);
    send_byte(pat[2], 1'b0);
    end_checks(1'b0);

    // cyclic sweep (R8 R9 R10)
    for (int n = 1; n <= 32; n++) begin
      set_pat(n + 100);
      load(n, n[1]);
      cmd(8'h24);
      chk(tx_active, "R8 cyclic started", tx_active, 1);
      for (int lap = 0; lap < 2; lap++)
        for (int i = 0; i < n; i++) send_byte(pat[i], 1'b1);
      chk(tx_active && tx_line == pat[0][0], "R8 wrapped to first", tx_line, pat[0][0]);
      if (n[0] == 1'b0) begin
        cmd(8'h00);
        chk(!tx_active && tx_line, "R9 stopped", {tx_active, tx_line}, 1);
        chk(!pool_ready, "R9 contents kept", pool_ready, 0);
        cmd(8'h04);
        for (int i = 0; i < n; i++) send_byte(pat[i], 1'b0);
        end_checks(1'b0);
      end else begin
        cmd(8'h01);
        chk(!tx_active && tx_line, "R10 soft reset idle", {tx_active, tx_line}, 1);
        chk(pool_ready, "R10 drain pulse", pool_ready, 1);
        @(negedge clk);
        cmd(8'h04);
        chk(!tx_active, "R10 buffer emptied", tx_active, 0);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule